// File: doc/BRIEF.md
# Multicore Private Window Decoder

This block is the register slave for an 8 KiB private peripheral window that a small multiprocessor cluster shares. It takes a single-beat bus (access strobe, write enable, 13-bit byte address, write data) and splits the window into fixed sub-regions. It answers the snoop-control registers itself. For every other sub-region it raises exactly one select line and passes on the offset inside that sub-region, so that the interrupt interfaces, timers, watchdogs and distributor outside the block can serve the access.

The number of processors, `NCPU`, is a parameter from 1 to 4. Each per-processor resource has `NCPU+1` slots. Slot 0 is the alias for "the processor issuing the access", and slot n+1 belongs to processor n. The select outputs and the local offset are combinational in the access cycle. Read data and the error flag are registered and are valid in the cycle after the access. For sub-regions outside the block, `rdata_o` stays zero, because those slaves return their own data.

Top module: `mpr_private_window`

## Requirements
- R1: While reset is held and after it is released, `err_o` and `rdata_o` are 0, and a read of the control word at offset 0x000 returns 0.
- R2: A write to offset 0x000 stores only bit 0 of the write data. A later read there returns that bit in bit 0 and zeros in all other bits.
- R3: A read at offset 0x004 returns `NCPU-1` in bits [3:0] and, starting at bit 4, a mask with one set bit per processor (value `((1<<NCPU)-1)<<4 | (NCPU-1)`). It does not flag an error.
- R4: Reads at 0x008 and 0x00C return 0 without an error. A write to 0x00C leaves the control word unchanged and flags no error.
- R5: Any other offset in 0x000–0x0FF flags an error on read or write and reads 0. A write there leaves the control word unchanged.
- R6: Addresses 0x100 + k·0x100, for k from 0 to NCPU, assert `iface_sel_o[k]`, with `local_off_o` = address bits [7:0].
- R7: In page 0x600 + k·0x100 (k from 0 to NCPU), byte offsets 0x00–0x1F assert `tmr_sel_o[k]` and 0x20–0x3F assert `wdog_sel_o[k]`, with `local_off_o` = address bits [4:0]. Bytes 0x40–0xFF of that page are unmapped.
- R8: Addresses 0x1000–0x1FFF assert `dist_sel_o`, with `local_off_o` = address bits [11:0].
- R9: An access to an unmapped address raises no select line and returns 0 in `rdata_o`. `err_o` is high for exactly the one cycle after the access.
- R10: At most one select line is high at a time. With no access, all select lines and `local_off_o` are 0. `local_off_o` is 0 for snoop-control and unmapped accesses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| acc_i | input | 1 | Access strobe, one beat per cycle |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 13 | Byte address within the window |
| wdata_i | input | DW | Write data |
| rdata_o | output | DW | Read data, registered (cycle after the access) |
| err_o | output | 1 | Bad access flag, registered one-cycle pulse |
| iface_sel_o | output | NCPU+1 | Interrupt interface select per slot |
| tmr_sel_o | output | NCPU+1 | Timer select per slot |
| wdog_sel_o | output | NCPU+1 | Watchdog select per slot |
| dist_sel_o | output | 1 | Distributor select |
| local_off_o | output | 12 | Offset within the selected sub-region |

## Verification
The bench builds the block with `NCPU = 2`. In that configuration the interface pages 0x400–0x5FF and the timer pages 0x900–0xAFF are unmapped, so the edge of the slot range, the partly used timer page and the gaps can all be checked. The bench reads every byte address of the window and compares each result with a model computed from the page and byte arithmetic. Before the sweep, directed writes exercise the control bit, the ignored invalidate and writes to bad offsets.

// File: rtl/mpr_pkg.sv
package mpr_pkg;
  localparam int unsigned ADDR_W = 13;
  localparam int unsigned OFF_W  = 12;

  typedef enum logic [2:0] {
    RG_NONE,
    RG_SNOOP,
    RG_IFACE,
    RG_TIMER,
    RG_WDOG,
    RG_DIST
  } region_e;
endpackage

// File: rtl/mpr_window_decode.sv
module mpr_window_decode
  import mpr_pkg::*;
#(
  parameter int unsigned NCPU   = 4,
  parameter int unsigned SLOT_W = 3
) (
  input  logic [ADDR_W-1:0] addr_i,
  output region_e           region_o,
  output logic [SLOT_W-1:0] slot_o,
  output logic [OFF_W-1:0]  off_o
);
  localparam logic [4:0] IFACE_FIRST = 5'd1;
  localparam logic [4:0] IFACE_LAST  = 5'(NCPU + 1);
  localparam logic [4:0] TMR_FIRST   = 5'd6;
  localparam logic [4:0] TMR_LAST    = 5'(6 + NCPU);

  logic [4:0] page;
  logic [7:0] inpage;

  assign page   = addr_i[12:8];
  assign inpage = addr_i[7:0];

  always_comb begin
    region_o = RG_NONE;
    slot_o   = '0;
    off_o    = '0;
    if (addr_i[12]) begin
      region_o = RG_DIST;
      off_o    = addr_i[11:0];
    end else if (page == 5'd0) begin
      region_o = RG_SNOOP;
      off_o    = {4'd0, inpage};
    end else if (page >= IFACE_FIRST && page <= IFACE_LAST) begin
      region_o = RG_IFACE;
      slot_o   = SLOT_W'(page - IFACE_FIRST);
      off_o    = {4'd0, inpage};
    end else if (page >= TMR_FIRST && page <= TMR_LAST && inpage[7:6] == 2'b00) begin
      region_o = inpage[5] ? RG_WDOG : RG_TIMER;
      slot_o   = SLOT_W'(page - TMR_FIRST);
      off_o    = {7'd0, inpage[4:0]};
    end
  end
endmodule

// File: rtl/mpr_snoop_regs.sv
module mpr_snoop_regs #(
  parameter int unsigned NCPU = 4,
  parameter int unsigned DW   = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          hit_i,
  input  logic          we_i,
  input  logic [7:0]    off_i,
  input  logic          wbit_i,
  output logic [DW-1:0] rd_o,
  output logic          bad_o
);
  localparam logic [7:0] OFF_CTRL = 8'h00;
  localparam logic [7:0] OFF_CFG  = 8'h04;
  localparam logic [7:0] OFF_STAT = 8'h08;
  localparam logic [7:0] OFF_INV  = 8'h0C;
  localparam logic [DW-1:0] CFG_WORD =
    DW'((((1 << NCPU) - 1) << 4) | (NCPU - 1));

  logic ctrl_q, ctrl_d, ctrl_en;

  assign ctrl_en = hit_i && we_i && (off_i == OFF_CTRL);

  always_comb begin
    ctrl_d = ctrl_q;
    if (ctrl_en) ctrl_d = wbit_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ctrl_q <= 1'b0;
    else         ctrl_q <= ctrl_d;
  end

  always_comb begin
    rd_o  = '0;
    bad_o = 1'b0;
    unique case (off_i)
      OFF_CTRL: rd_o = {{(DW-1){1'b0}}, ctrl_q};
      OFF_CFG:  rd_o = CFG_WORD;
      OFF_STAT, OFF_INV: rd_o = '0;
      default:  bad_o = hit_i;
    endcase
  end

  AST_CTRL_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit_i && we_i && off_i != OFF_CTRL) |=> $stable(ctrl_q)); // R5
  AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hit_i |=> $stable(ctrl_q)); // R4
endmodule

// File: rtl/mpr_private_window.sv
module mpr_private_window
  import mpr_pkg::*;
#(
  parameter int unsigned NCPU = 4,
  parameter int unsigned DW   = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              acc_i,
  input  logic              we_i,
  input  logic [12:0]       addr_i,
  input  logic [DW-1:0]     wdata_i,
  output logic [DW-1:0]     rdata_o,
  output logic              err_o,
  output logic [NCPU:0]     iface_sel_o,
  output logic [NCPU:0]     tmr_sel_o,
  output logic [NCPU:0]     wdog_sel_o,
  output logic              dist_sel_o,
  output logic [OFF_W-1:0]  local_off_o
);
  localparam int unsigned NSLOT  = NCPU + 1;
  localparam int unsigned SLOT_W = (NSLOT > 1) ? $clog2(NSLOT) : 1;

  logic [1:0] rst_sync_q;
  logic       rst_n;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rst_sync_q <= 2'b00;
    else         rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n = rst_sync_q[1];

  region_e           region;
  logic [SLOT_W-1:0] slot;
  logic [OFF_W-1:0]  off;

  mpr_window_decode #(.NCPU(NCPU), .SLOT_W(SLOT_W)) u_decode (
    .addr_i   (addr_i),
    .region_o (region),
    .slot_o   (slot),
    .off_o    (off)
  );

  logic          snoop_hit, snoop_bad;
  logic [DW-1:0] snoop_rd;

  assign snoop_hit = acc_i && (region == RG_SNOOP);

  mpr_snoop_regs #(.NCPU(NCPU), .DW(DW)) u_snoop (
    .clk_i  (clk_i),
    .rst_ni (rst_n),
    .hit_i  (snoop_hit),
    .we_i   (we_i),
    .off_i  (off[7:0]),
    .wbit_i (wdata_i[0]),
    .rd_o   (snoop_rd),
    .bad_o  (snoop_bad)
  );

  for (genvar s = 0; s < NSLOT; s++) begin : g_slot
    assign iface_sel_o[s] = acc_i && (region == RG_IFACE) && (slot == SLOT_W'(s));
    assign tmr_sel_o[s]   = acc_i && (region == RG_TIMER) && (slot == SLOT_W'(s));
    assign wdog_sel_o[s]  = acc_i && (region == RG_WDOG)  && (slot == SLOT_W'(s));
  end
  assign dist_sel_o = acc_i && (region == RG_DIST);

  logic ext_hit;
  assign ext_hit     = acc_i && (region inside {RG_IFACE, RG_TIMER, RG_WDOG, RG_DIST});
  assign local_off_o = ext_hit ? off : '0;

  logic [DW-1:0] rdata_d;
  logic          err_d;

  always_comb begin
    rdata_d = '0;
    err_d   = 1'b0;
    if (acc_i) begin
      if (region == RG_NONE) err_d = 1'b1;
      else if (region == RG_SNOOP) begin
        err_d = snoop_bad;
        if (!we_i && !snoop_bad) rdata_d = snoop_rd;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) begin
      rdata_o <= '0;
      err_o   <= 1'b0;
    end else begin
      rdata_o <= rdata_d;
      err_o   <= err_d;
    end
  end

  AST_SEL_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_n)
    $onehot0({iface_sel_o, tmr_sel_o, wdog_sel_o, dist_sel_o})); // R10
  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_n)
    !acc_i |-> ({iface_sel_o, tmr_sel_o, wdog_sel_o, dist_sel_o} == '0 && local_off_o == '0)); // R10
  AST_ERR_AFTER_ACC: assert property (@(posedge clk_i) disable iff (!rst_n)
    !acc_i |=> !err_o); // R9
  AST_ERR_NO_DATA: assert property (@(posedge clk_i) disable iff (!rst_n)
    err_o |-> rdata_o == '0); // R9
  AST_DIST_OFF: assert property (@(posedge clk_i) disable iff (!rst_n)
    dist_sel_o |-> local_off_o == addr_i[11:0]); // R8
  AST_CFG_COUNT: assert property (@(posedge clk_i) disable iff (!rst_n)
    (acc_i && !we_i && addr_i == 13'h004) |=> rdata_o[3:0] == 4'(NCPU - 1)); // R3
endmodule

// File: tb/mpr_private_window_tb.sv
module mpr_private_window_tb_top;
  localparam int NC = 2;
  localparam int DW = 32;
  localparam time CLK_PERIOD = 10ns;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic acc = 1'b0, we = 1'b0;
  logic [12:0] addr = '0;
  logic [DW-1:0] wdata = '0;
  logic [DW-1:0] rdata;
  logic err;
  logic [NC:0] isel, tsel, wsel;
  logic dsel;
  logic [11:0] loff;

  int n_chk = 0, n_bad = 0;
  int ctrl_model = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mpr_private_window #(.NCPU(NC), .DW(DW)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .acc_i(acc), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .err_o(err), .iface_sel_o(isel),
    .tmr_sel_o(tsel), .wdog_sel_o(wsel), .dist_sel_o(dsel), .local_off_o(loff)
  );

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  // Model of one access at byte address a: selects, offset, data, error.
  task automatic model(input int a, output logic [NC:0] ei, output logic [NC:0] et,
                       output logic [NC:0] ew, output logic ed, output int eo,
                       output int er, output logic ee, output string rq);
    int pg, bt;
    pg = a >> 8; bt = a & 8'hFF;
    ei = '0; et = '0; ew = '0; ed = 1'b0; eo = 0; er = 0; ee = 1'b0;
    if (a >= 'h1000) begin
      ed = 1'b1; eo = a & 'hFFF; rq = "R8";
    end else if (pg == 0) begin
      rq = "R5";
      if (bt == 0) begin er = ctrl_model; rq = "R2"; end
      else if (bt == 4) begin er = (((1 << NC) - 1) << 4) | (NC - 1); rq = "R3"; end
      else if (bt == 8 || bt == 'hC) rq = "R4";
      else ee = 1'b1;
    end else if (pg <= NC + 1) begin
      ei[pg-1] = 1'b1; eo = bt; rq = "R6";
    end else if (pg >= 6 && pg <= 6 + NC && bt < 'h40) begin
      if (bt < 'h20) et[pg-6] = 1'b1; else ew[pg-6] = 1'b1;
      eo = bt & 'h1F; rq = "R7";
    end else begin
      ee = 1'b1; rq = "R9";
    end
  endtask

  // One access: selects are checked in the access cycle, data and error in the next.
  task automatic access(input int a, input logic w, input int wd);
    logic [NC:0] ei, et, ew; logic ed, ee; int eo, er; string rq;
    model(a, ei, et, ew, ed, eo, er, ee, rq);
    if (w) er = 0;
    @(negedge clk);
    acc = 1'b1; we = w; addr = 13'(a); wdata = wd;
    #1;
    check({rq, "/R10 sel"}, {isel, tsel, wsel, dsel}, {ei, et, ew, ed});
    check({rq, " off"}, 64'(loff), 64'(eo));
    @(negedge clk);
    acc = 1'b0; we = 1'b0;
    check({rq, " data+err"}, {rdata, 31'd0, err}, {32'(er), 31'd0, ee});
  endtask

  initial begin
    #(CLK_PERIOD * 190000);
    n_bad++;
    $display("FAIL watchdog: actual=timeout expected=done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset err", 64'(err), 0);
    check("R1 reset rdata", 64'(rdata), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    access('h000, 1'b0, 0);                  // R1 control reads 0
    access('h000, 1'b1, 32'hFFFF_FFFF); ctrl_model = 1;
    access('h000, 1'b0, 0);                  // R2 keeps bit 0
    access('h000, 1'b1, 32'hFFFF_FFFE); ctrl_model = 0;
    access('h000, 1'b0, 0);                  // R2
    access('h000, 1'b1, 1); ctrl_model = 1;
    access('h00C, 1'b1, 0);                  // R4 invalidate ignored
    access('h000, 1'b0, 0);
    access('h010, 1'b1, 0);                  // R5 bad write, ctrl unchanged
    access('h000, 1'b0, 0);
    access('h0FC, 1'b1, 0);                  // R5
    access('h000, 1'b0, 0);
    access('h004, 1'b0, 0);                  // R3
    access('hB00, 1'b0, 0);                  // R9 err pulse
    @(negedge clk);
    check("R9 err one cycle", 64'(err), 0);
    for (int a = 0; a < 'h2000; a++) access(a, 1'b0, 0);
    finish_run();
  end
endmodule